// File: doc/BRIEF.md
# Middle-Level MESI Line Controller

This block holds the coherence state of one line in a private middle-level cache. The line sits between an inner cache, which sends load, store and eviction requests and returns writebacks, and a shared outer directory, which returns fills and write-back acknowledgements and probes the line with invalidations and forwarded read or ownership requests. The controller decides which of these events it takes in a cycle. It walks the line through its stable and transient states, keeps the line data and a dirty bit, and emits one-cycle pulses on its outward request, unblock, invalidation-ack, forwarded-data and inward-data channels.

Three events are arbitrated in a fixed order. An outer response is always taken. An outer probe is taken next, but only when no read or ownership request is pending. An inner request is taken last, and only when the line is stable. A request or probe that is refused keeps its valid high and is taken once the line allows it. Inner writebacks use a separate channel. They change the stored block only when they carry a dirty flag. The line is released only when the outer level acknowledges its write-back.

Top module: `mlc_line_ctrl`

## Requirements
- R1: After reset, `line_state` is 0 (Invalid), `req_ready` is high and every pulse output (`oreq_valid`, `unblk_valid`, `iack_valid`, `fwd_valid`, `idata_valid`) is low.
- R2: A load (`req_kind`=0) taken in Invalid issues a GETS (`oreq_kind`=0) for `req_addr` and moves the line to read-pending (state 4). A store (`req_kind`=1) taken in Invalid issues a GETX (`oreq_kind`=1) and moves it to write-pending (state 5).
- R3: An invalidation (`prb_kind`=0) taken in Invalid returns an `iack_valid` pulse tagged with `prb_addr`, and the line stays in Invalid.
- R4: In read-pending, `prb_ready` stays low for every probe kind until the fill arrives. A probe held through the fill is taken on the next cycle.
- R5: A plain fill (`rsp_kind`=0) in read-pending moves the line to Shared (state 1) and sends the block inward with `idata_excl` low. An unblock with `unblk_excl` low and the line address is sent only when `rsp_peer` marks the sender as a peer middle cache.
- R6: An exclusive fill (`rsp_kind`=1) sends the block inward with `idata_excl` high and an unblock with `unblk_excl` high. It moves read-pending to Exclusive (state 2) and write-pending to Modified (state 3).
- R7: An inner writeback with `wb_dirty` high replaces the stored block and sets the dirty bit. With `wb_dirty` low the block and the dirty bit are left unchanged.
- R8: An eviction (`req_kind`=2) in Exclusive or Modified issues a PUTX (`oreq_kind`=2) for the line address and moves the line to writeback-pending (state 6). The PUTX has `oreq_has_data` high and carries the block only if the line is dirty. Otherwise it has `oreq_has_data` low and zero data. An eviction in Shared drops the line to Invalid silently, and one in Invalid has no effect.
- R9: A write-back ack (`rsp_kind`=2) in writeback-pending or write-back-sink (state 7) moves the line to Invalid and clears its dirty bit.
- R10: A forwarded GETX (`prb_kind`=2) in Exclusive or Modified sends the stored block on `fwd_data`, frees the line and moves it to Invalid. A forwarded GETS (`prb_kind`=1) there sends the block and moves the line to Shared. A forwarded GETX in writeback-pending sends the block and moves the line to write-back-sink.
- R11: `req_ready` is low whenever the line is in a transient state (4 to 7), and also while a response or probe is valid. Each refused request is taken once the line is stable.
- R12: A load hit in Shared, Exclusive or Modified returns the stored block inward, with `idata_excl` high except in Shared. A store in Exclusive moves the line to Modified with no outward request. A store in Shared issues a GETX and moves the line to write-pending.
- R13: An invalidation taken in Shared, Exclusive or Modified returns an ack and moves the line to Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Inner request valid |
| req_kind | input | 2 | 0 load, 1 store, 2 eviction |
| req_addr | input | ADDR_W | Inner request line address |
| req_ready | output | 1 | Inner request taken this cycle when valid |
| wb_valid | input | 1 | Inner writeback valid |
| wb_dirty | input | 1 | Writeback carries modified data |
| wb_data | input | DATA_W | Writeback block |
| rsp_valid | input | 1 | Outer response valid, always taken |
| rsp_kind | input | 2 | 0 fill, 1 exclusive fill, 2 write-back ack |
| rsp_peer | input | 1 | Fill was sourced by a peer middle cache |
| rsp_data | input | DATA_W | Fill block |
| prb_valid | input | 1 | Outer probe valid |
| prb_kind | input | 2 | 0 invalidate, 1 forwarded GETS, 2 forwarded GETX |
| prb_addr | input | ADDR_W | Probe address, echoed on the ack |
| prb_ready | output | 1 | Probe taken this cycle when valid |
| oreq_valid | output | 1 | Outward request pulse |
| oreq_kind | output | 2 | 0 GETS, 1 GETX, 2 PUTX |
| oreq_addr | output | ADDR_W | Outward request address |
| oreq_has_data | output | 1 | PUTX carries a block |
| oreq_data | output | DATA_W | PUTX block, zero when none |
| unblk_valid | output | 1 | Unblock pulse to the directory |
| unblk_excl | output | 1 | Unblock is for an exclusive grant |
| unblk_addr | output | ADDR_W | Unblock line address |
| iack_valid | output | 1 | Invalidation-ack pulse |
| iack_addr | output | ADDR_W | Invalidation-ack address |
| fwd_valid | output | 1 | Data-to-requestor pulse |
| fwd_data | output | DATA_W | Block sent to the requestor |
| idata_valid | output | 1 | Inward data pulse |
| idata_excl | output | 1 | Inward data grants write permission |
| idata_data | output | DATA_W | Inward block |
| line_state | output | 3 | 0 I, 1 S, 2 E, 3 M, 4 read-pending, 5 write-pending, 6 writeback-pending, 7 write-back-sink |

## Verification
Every result of an event taken at a clock edge is registered, so the request, unblock, ack, forwarded-data and inward-data pulses and the new `line_state` all appear after that same edge and last exactly one cycle. `req_ready` and `prb_ready` are combinational and are due in the cycle the input is presented. The bench drives inputs on the falling edge and checks the ready signals one nanosecond later. It then waits one falling edge, so that exactly one rising edge has passed, and checks the outputs that edge produced before changing any input. Pulse width is confirmed by looking one falling edge further. Effects that cannot be seen directly, such as an ignored clean writeback or a dirty bit cleared on release, are observed through a later PUTX or forwarded block.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

   typedef enum logic [2:0] {
      ST_I    = 3'd0,
      ST_S    = 3'd1,
      ST_E    = 3'd2,
      ST_M    = 3'd3,
      ST_RD   = 3'd4,
      ST_WR   = 3'd5,
      ST_WB   = 3'd6,
      ST_SINK = 3'd7
   } lstate_e;

   localparam logic [1:0] RQ_LOAD  = 2'd0;
   localparam logic [1:0] RQ_STORE = 2'd1;
   localparam logic [1:0] RQ_EVICT = 2'd2;

   localparam logic [1:0] RS_DATA  = 2'd0;
   localparam logic [1:0] RS_XDATA = 2'd1;
   localparam logic [1:0] RS_WBACK = 2'd2;

   localparam logic [1:0] PB_INV   = 2'd0;
   localparam logic [1:0] PB_GETS  = 2'd1;
   localparam logic [1:0] PB_GETX  = 2'd2;

   localparam logic [1:0] OQ_GETS  = 2'd0;
   localparam logic [1:0] OQ_GETX  = 2'd1;
   localparam logic [1:0] OQ_PUTX  = 2'd2;

   typedef struct packed {
      logic       oreq;
      logic [1:0] okind;
      logic       iack;
      logic       unblk;
      logic       unblk_x;
      logic       fwd;
      logic       idata;
      logic       idata_x;
      logic       idata_fill;
      logic       alloc;
      logic       fill;
      logic       free;
   } act_t;

endpackage

// File: rtl/mlc_gate.sv
module mlc_gate
   import mlc_pkg::*;
(
   input  lstate_e state,
   input  logic    req_valid,
   input  logic    rsp_valid,
   input  logic    prb_valid,
   output logic    req_take,
   output logic    rsp_take,
   output logic    prb_take,
   output logic    req_ready,
   output logic    prb_ready
);
   logic stable;
   logic read_or_own_pending;

   always_comb begin
      stable              = (state == ST_I) || (state == ST_S) ||
                            (state == ST_E) || (state == ST_M);
      read_or_own_pending = (state == ST_RD) || (state == ST_WR);
      rsp_take  = rsp_valid;
      prb_ready = !rsp_valid && !read_or_own_pending;
      prb_take  = prb_valid && prb_ready;
      req_ready = stable && !rsp_valid && !prb_valid;
      req_take  = req_valid && req_ready;
   end
endmodule

// File: rtl/mlc_next.sv
module mlc_next
   import mlc_pkg::*;
(
   input  lstate_e    state,
   input  logic       rsp_take,
   input  logic [1:0] rsp_kind,
   input  logic       rsp_peer,
   input  logic       prb_take,
   input  logic [1:0] prb_kind,
   input  logic       req_take,
   input  logic [1:0] req_kind,
   output lstate_e    nxt,
   output act_t       act
);
   always_comb begin
      nxt = state;
      act = '0;
      if (rsp_take) begin
         unique case (rsp_kind)
            RS_DATA: if (state == ST_RD) begin
               nxt = ST_S; act.fill = 1'b1; act.idata = 1'b1;
               act.idata_fill = 1'b1; act.unblk = rsp_peer;
            end
            RS_XDATA: if (state == ST_RD || state == ST_WR) begin
               nxt = (state == ST_RD) ? ST_E : ST_M;
               act.fill = 1'b1; act.idata = 1'b1; act.idata_x = 1'b1;
               act.idata_fill = 1'b1; act.unblk = 1'b1; act.unblk_x = 1'b1;
            end
            RS_WBACK: if (state == ST_WB || state == ST_SINK) begin
               nxt = ST_I; act.free = 1'b1;
            end
            default: ;
         endcase
      end else if (prb_take) begin
         unique case (prb_kind)
            PB_INV: begin
               act.iack = 1'b1;
               if (state == ST_S || state == ST_E || state == ST_M) begin
                  nxt = ST_I; act.free = 1'b1;
               end else if (state == ST_WB) begin
                  nxt = ST_SINK;
               end
            end
            PB_GETS: if (state == ST_E || state == ST_M || state == ST_WB) begin
               act.fwd = 1'b1;
               if (state != ST_WB) nxt = ST_S;
            end
            PB_GETX: begin
               if (state == ST_E || state == ST_M) begin
                  act.fwd = 1'b1; nxt = ST_I; act.free = 1'b1;
               end else if (state == ST_WB) begin
                  act.fwd = 1'b1; nxt = ST_SINK;
               end else if (state == ST_S) begin
                  act.iack = 1'b1; nxt = ST_I; act.free = 1'b1;
               end
            end
            default: ;
         endcase
      end else if (req_take) begin
         unique case (req_kind)
            RQ_LOAD: if (state == ST_I) begin
               nxt = ST_RD; act.oreq = 1'b1; act.okind = OQ_GETS; act.alloc = 1'b1;
            end else begin
               act.idata = 1'b1; act.idata_x = (state != ST_S);
            end
            RQ_STORE: if (state == ST_I) begin
               nxt = ST_WR; act.oreq = 1'b1; act.okind = OQ_GETX; act.alloc = 1'b1;
            end else if (state == ST_S) begin
               nxt = ST_WR; act.oreq = 1'b1; act.okind = OQ_GETX;
            end else if (state == ST_E) begin
               nxt = ST_M;
            end
            RQ_EVICT: if (state == ST_S) begin
               nxt = ST_I; act.free = 1'b1;
            end else if (state == ST_E || state == ST_M) begin
               nxt = ST_WB; act.oreq = 1'b1; act.okind = OQ_PUTX;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mlc_line_store.sv
module mlc_line_store #(
   parameter int DATA_W       = 64,
   parameter bit ZERO_ON_FREE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              wb_valid,
   input  logic              wb_dirty,
   input  logic [DATA_W-1:0] wb_data,
   input  logic              free,
   output logic [DATA_W-1:0] data,
   output logic              dirty
);
   logic wb_take;
   assign wb_take = wb_valid && wb_dirty;

   always_ff @(posedge clk) begin
      if (!rst_n)           dirty <= 1'b0;
      else if (free)        dirty <= 1'b0;
      else if (fill)        dirty <= 1'b0;
      else if (wb_take)     dirty <= 1'b1;
   end

   generate
      if (ZERO_ON_FREE) begin : g_zero
         always_ff @(posedge clk) begin
            if (!rst_n)       data <= '0;
            else if (free)    data <= '0;
            else if (fill)    data <= fill_data;
            else if (wb_take) data <= wb_data;
         end
      end else begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n)       data <= '0;
            else if (fill)    data <= fill_data;
            else if (wb_take && !free) data <= wb_data;
         end
      end
   endgenerate

   assert_clean_wb_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_dirty && !fill && !free) |=> ($stable(data) && $stable(dirty)));
endmodule

// File: rtl/mlc_line_ctrl.sv
module mlc_line_ctrl
   import mlc_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 64,
   parameter bit ZERO_ON_FREE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   input  logic              wb_valid,
   input  logic              wb_dirty,
   input  logic [DATA_W-1:0] wb_data,
   input  logic              rsp_valid,
   input  logic [1:0]        rsp_kind,
   input  logic              rsp_peer,
   input  logic [DATA_W-1:0] rsp_data,
   input  logic              prb_valid,
   input  logic [1:0]        prb_kind,
   input  logic [ADDR_W-1:0] prb_addr,
   output logic              prb_ready,
   output logic              oreq_valid,
   output logic [1:0]        oreq_kind,
   output logic [ADDR_W-1:0] oreq_addr,
   output logic              oreq_has_data,
   output logic [DATA_W-1:0] oreq_data,
   output logic              unblk_valid,
   output logic              unblk_excl,
   output logic [ADDR_W-1:0] unblk_addr,
   output logic              iack_valid,
   output logic [ADDR_W-1:0] iack_addr,
   output logic              fwd_valid,
   output logic [DATA_W-1:0] fwd_data,
   output logic              idata_valid,
   output logic              idata_excl,
   output logic [DATA_W-1:0] idata_data,
   output logic [2:0]        line_state
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_cfg
         initial $error("mlc_line_ctrl: ADDR_W and DATA_W must be positive");
      end
   endgenerate

   lstate_e           state_q, state_d;
   act_t              act;
   logic              req_take, rsp_take, prb_take;
   logic [ADDR_W-1:0] line_addr;
   logic [DATA_W-1:0] blk;
   logic              dirty;

   mlc_gate u_gate (
      .state(state_q), .req_valid(req_valid), .rsp_valid(rsp_valid),
      .prb_valid(prb_valid), .req_take(req_take), .rsp_take(rsp_take),
      .prb_take(prb_take), .req_ready(req_ready), .prb_ready(prb_ready)
   );

   mlc_next u_next (
      .state(state_q), .rsp_take(rsp_take), .rsp_kind(rsp_kind),
      .rsp_peer(rsp_peer), .prb_take(prb_take), .prb_kind(prb_kind),
      .req_take(req_take), .req_kind(req_kind), .nxt(state_d), .act(act)
   );

   mlc_line_store #(.DATA_W(DATA_W), .ZERO_ON_FREE(ZERO_ON_FREE)) u_store (
      .clk(clk), .rst_n(rst_n), .fill(act.fill), .fill_data(rsp_data),
      .wb_valid(wb_valid), .wb_dirty(wb_dirty), .wb_data(wb_data),
      .free(act.free), .data(blk), .dirty(dirty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_I;
         line_addr <= '0;
      end else begin
         state_q <= state_d;
         if (act.alloc) line_addr <= req_addr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oreq_valid <= 1'b0; oreq_kind <= '0; oreq_addr <= '0;
         oreq_has_data <= 1'b0; oreq_data <= '0;
         unblk_valid <= 1'b0; unblk_excl <= 1'b0; unblk_addr <= '0;
         iack_valid <= 1'b0; iack_addr <= '0;
         fwd_valid <= 1'b0; fwd_data <= '0;
         idata_valid <= 1'b0; idata_excl <= 1'b0; idata_data <= '0;
      end else begin
         oreq_valid    <= act.oreq;
         oreq_kind     <= act.okind;
         oreq_addr     <= act.alloc ? req_addr : line_addr;
         oreq_has_data <= act.oreq && (act.okind == OQ_PUTX) && dirty;
         oreq_data     <= (act.oreq && (act.okind == OQ_PUTX) && dirty) ? blk : '0;
         unblk_valid   <= act.unblk;
         unblk_excl    <= act.unblk_x;
         unblk_addr    <= line_addr;
         iack_valid    <= act.iack;
         iack_addr     <= prb_addr;
         fwd_valid     <= act.fwd;
         fwd_data      <= blk;
         idata_valid   <= act.idata;
         idata_excl    <= act.idata_x;
         idata_data    <= act.idata_fill ? rsp_data : blk;
      end
   end

   assign line_state = state_q;

   assert_probe_held_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RD && prb_valid) |-> !prb_ready);

   assert_req_stalled_transient_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && state_q inside {ST_RD, ST_WR, ST_WB, ST_SINK}) |-> !req_ready);

   assert_wback_frees_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q inside {ST_WB, ST_SINK} && rsp_valid && rsp_kind == RS_WBACK)
      |=> (line_state == 3'd0));

   assert_no_data_without_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (oreq_valid && !oreq_has_data) |-> (oreq_data == '0));

   assert_unblock_after_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      unblk_valid |-> $past(state_q == ST_RD || state_q == ST_WR));

   assert_inv_in_idle_acks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_I && prb_valid && prb_ready && prb_kind == PB_INV)
      |=> (iack_valid && line_state == 3'd0));
endmodule

// File: tb/sim_mlc_line_ctrl.sv
module sim_mlc_line_ctrl;
   localparam int AW = 32;
   localparam int DW = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic req_valid = 0; logic [1:0] req_kind = 0; logic [AW-1:0] req_addr = 0;
   logic wb_valid = 0, wb_dirty = 0; logic [DW-1:0] wb_data = 0;
   logic rsp_valid = 0; logic [1:0] rsp_kind = 0; logic rsp_peer = 0; logic [DW-1:0] rsp_data = 0;
   logic prb_valid = 0; logic [1:0] prb_kind = 0; logic [AW-1:0] prb_addr = 0;
   logic req_ready, prb_ready, oreq_valid, oreq_has_data, unblk_valid, unblk_excl;
   logic iack_valid, fwd_valid, idata_valid, idata_excl;
   logic [1:0] oreq_kind; logic [2:0] line_state;
   logic [AW-1:0] oreq_addr, unblk_addr, iack_addr;
   logic [DW-1:0] oreq_data, fwd_data, idata_data;

   mlc_line_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_ready(req_ready), .wb_valid(wb_valid),
      .wb_dirty(wb_dirty), .wb_data(wb_data), .rsp_valid(rsp_valid),
      .rsp_kind(rsp_kind), .rsp_peer(rsp_peer), .rsp_data(rsp_data),
      .prb_valid(prb_valid), .prb_kind(prb_kind), .prb_addr(prb_addr),
      .prb_ready(prb_ready), .oreq_valid(oreq_valid), .oreq_kind(oreq_kind),
      .oreq_addr(oreq_addr), .oreq_has_data(oreq_has_data), .oreq_data(oreq_data),
      .unblk_valid(unblk_valid), .unblk_excl(unblk_excl), .unblk_addr(unblk_addr),
      .iack_valid(iack_valid), .iack_addr(iack_addr), .fwd_valid(fwd_valid),
      .fwd_data(fwd_data), .idata_valid(idata_valid), .idata_excl(idata_excl),
      .idata_data(idata_data), .line_state(line_state)
   );

   int checks = 0, failures = 0;
   bit done = 0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(); @(negedge clk); endtask
   task automatic quiet();
      req_valid = 0; wb_valid = 0; rsp_valid = 0; prb_valid = 0;
   endtask
   task automatic give_req(logic [1:0] k, logic [AW-1:0] a);
      req_valid = 1; req_kind = k; req_addr = a; cyc(); quiet();
   endtask
   task automatic give_rsp(logic [1:0] k, logic peer, logic [DW-1:0] d);
      rsp_valid = 1; rsp_kind = k; rsp_peer = peer; rsp_data = d; cyc(); quiet();
   endtask
   task automatic give_prb(logic [1:0] k, logic [AW-1:0] a);
      prb_valid = 1; prb_kind = k; prb_addr = a; cyc(); quiet();
   endtask
   task automatic give_wb(logic dty, logic [DW-1:0] d);
      wb_valid = 1; wb_dirty = dty; wb_data = d; cyc(); quiet();
   endtask

   task automatic t_reset();
      chk("R1 state", line_state, 0);
      chk("R1 req_ready", req_ready, 1);
      chk("R1 pulses", {oreq_valid, unblk_valid, iack_valid, fwd_valid, idata_valid}, 0);
   endtask

   task automatic t_inv_idle();
      give_prb(0, 32'h40);
      chk("R3 iack", iack_valid, 1);
      chk("R3 iack addr", iack_addr, 32'h40);
      chk("R3 state", line_state, 0);
      cyc();
      chk("R3 single pulse", iack_valid, 0);
   endtask

   task automatic t_peer_read_with_probe();
      give_req(0, 32'h100);
      chk("R2 GETS", {oreq_valid, oreq_kind}, {1'b1, 2'd0});
      chk("R2 addr", oreq_addr, 32'h100);
      chk("R2 state", line_state, 4);
      req_valid = 1; req_kind = 1; req_addr = 32'h100; #1;
      chk("R11 stall in read", req_ready, 0);
      req_valid = 0;
      prb_valid = 1; prb_kind = 0; prb_addr = 32'h100; #1;
      chk("R4 probe held", prb_ready, 0);
      cyc(); #1;
      chk("R4 no ack while reading", iack_valid, 0);
      rsp_valid = 1; rsp_kind = 0; rsp_peer = 1; rsp_data = 64'hA1A1; cyc();
      rsp_valid = 0;
      chk("R5 state S", line_state, 1);
      chk("R5 idata", {idata_valid, idata_excl}, {1'b1, 1'b0});
      chk("R5 idata data", idata_data, 64'hA1A1);
      chk("R5 peer unblock", {unblk_valid, unblk_excl}, {1'b1, 1'b0});
      chk("R5 unblock addr", unblk_addr, 32'h100);
      #1 chk("R4 probe now ready", prb_ready, 1);
      cyc(); prb_valid = 0;
      chk("R13 ack after replay", iack_valid, 1);
      chk("R13 state I", line_state, 0);
   endtask

   task automatic t_dir_read_upgrade();
      give_req(0, 32'h200);
      give_rsp(0, 0, 64'hB2);
      chk("R5 dir fill S", line_state, 1);
      chk("R5 no unblock dir", unblk_valid, 0);
      give_req(0, 32'h200);
      chk("R12 load hit S", {idata_valid, idata_excl}, {1'b1, 1'b0});
      chk("R12 hit data", idata_data, 64'hB2);
      give_req(1, 32'h200);
      chk("R12 upgrade GETX", {oreq_valid, oreq_kind}, {1'b1, 2'd1});
      chk("R12 upgrade state", line_state, 5);
      give_rsp(1, 0, 64'hB3);
      chk("R6 state M", line_state, 3);
      chk("R6 idata excl", {idata_valid, idata_excl}, {1'b1, 1'b1});
      chk("R6 unblock excl", {unblk_valid, unblk_excl}, {1'b1, 1'b1});
      give_req(2, 32'h200);
      chk("R8 clean PUTX", {oreq_valid, oreq_kind, oreq_has_data}, {1'b1, 2'd2, 1'b0});
      chk("R8 clean data zero", oreq_data, 0);
      chk("R8 state WB", line_state, 6);
      req_valid = 1; req_kind = 0; #1;
      chk("R11 stall in WB", req_ready, 0);
      req_valid = 0;
      give_rsp(2, 0, 0);
      chk("R9 freed", line_state, 0);
   endtask

   task automatic t_excl_clean_wb();
      give_req(0, 32'h300);
      give_rsp(1, 0, 64'hC1);
      chk("R6 state E", line_state, 2);
      chk("R6 unblock excl", {unblk_valid, unblk_excl}, {1'b1, 1'b1});
      give_req(1, 32'h300);
      chk("R12 silent E->M", {oreq_valid, line_state}, {1'b0, 3'd3});
      give_wb(0, 64'hDEAD);
      give_prb(1, 32'h300);
      chk("R7 clean wb ignored", fwd_data, 64'hC1);
      chk("R10 fwd GETS", {fwd_valid, line_state}, {1'b1, 3'd1});
      give_req(2, 32'h300);
      chk("R8 evict S silent", {oreq_valid, line_state}, {1'b0, 3'd0});
   endtask

   task automatic t_dirty_wb_sink();
      give_req(1, 32'h400);
      chk("R2 GETX", {oreq_valid, oreq_kind, line_state}, {1'b1, 2'd1, 3'd5});
      give_rsp(1, 0, 64'hD3);
      chk("R6 IM->M", line_state, 3);
      give_wb(1, 64'hD4);
      give_req(2, 32'h400);
      chk("R8 dirty PUTX", {oreq_valid, oreq_kind, oreq_has_data}, {1'b1, 2'd2, 1'b1});
      chk("R7 dirty data", oreq_data, 64'hD4);
      chk("R8 PUTX addr", oreq_addr, 32'h400);
      give_prb(2, 32'h400);
      chk("R10 fwd in WB", {fwd_valid, line_state}, {1'b1, 3'd7});
      chk("R10 fwd data", fwd_data, 64'hD4);
      give_rsp(2, 0, 0);
      chk("R9 sink freed", line_state, 0);
      give_req(2, 32'h400);
      chk("R8 evict in I", {oreq_valid, line_state}, {1'b0, 3'd0});
   endtask

   task automatic t_fwd_getx_and_priority();
      give_req(0, 32'h500);
      give_rsp(1, 1, 64'hE5);
      req_valid = 1; req_kind = 0; prb_valid = 1; prb_kind = 2; #1;
      chk("R11 probe beats request", req_ready, 0);
      cyc(); prb_valid = 0;
      chk("R10 fwd GETX", {fwd_valid, line_state}, {1'b1, 3'd0});
      chk("R10 fwd data", fwd_data, 64'hE5);
      #1 chk("R11 replay ready", req_ready, 1);
      cyc(); req_valid = 0;
      chk("R11 replayed load", {oreq_valid, line_state}, {1'b1, 3'd4});
      give_rsp(0, 1, 64'hE6);
      give_req(1, 32'h500);
      give_rsp(1, 0, 64'hE7);
      give_wb(1, 64'hE8);
      give_req(2, 32'h500);
      give_rsp(2, 0, 0);
      give_req(1, 32'h600);
      give_rsp(1, 0, 64'hF1);
      give_req(2, 32'h600);
      chk("R9 dirty cleared on free", oreq_has_data, 0);
      give_rsp(2, 0, 0);
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1;
      cyc();
      t_reset();
      t_inv_idle();
      t_peer_read_with_probe();
      t_dir_read_upgrade();
      t_excl_clean_wb();
      t_dirty_wb_sink();
      t_fwd_getx_and_priority();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule